// File: doc/BRIEF.md
# MSI-X Vector Table and Pending-Bit Message Engine

This endpoint-side engine holds a per-vector interrupt table and a pending bit array in local storage. It turns interrupt requests from local logic into single-beat AXI memory writes. Each vector has its own 64-bit target address, its own 32-bit data word and its own mask bit. Software reaches the table and the pending bits through a simple word-wide register port. A local requester raises `irq_valid_i` and names a vector index.

Every request first marks its vector as pending. A selector then picks the lowest-numbered vector that is pending and deliverable: its own mask is clear and the function-wide mask input is low. The engine copies that vector's address and data into a holding register, clears the pending bit and drives one AXI write. It waits for the write response before it starts another write. A vector that is masked when it is requested stays pending. It is sent later, with the table contents of that moment, as soon as both masks are clear.

Top module: `msix_engine`

## Requirements
- R1: After reset every vector's mask bit reads 1, every pending bit reads 0, and `m_awvalid_o`/`m_wvalid_o` are low.
- R2: Vector n occupies byte offsets 16n..16n+15 of the register port: +0 address bits 31:0, +4 address bits 63:32, +8 message data, +12 control word with the mask in bit 0 and all other bits reading 0. Read data and `reg_rvalid_o` appear in the cycle after the read request.
- R3: The pending bits start at byte offset 16*NUM_VEC. Word k holds vectors 32k..32k+31, and vector v sits at bit v mod 32. Writes to this region are ignored.
- R4: A request for a vector whose mask bit is 1, or any request while `func_mask_i` is high, sets that vector's pending bit and issues no AXI write.
- R5: A deliverable request produces exactly one AXI write with `m_awaddr_o` = {word +4, word +0}, `m_wdata_o` = word +8, `m_wstrb_o` = 4'hF and `m_wlast_o` = 1. The pending bit is cleared once the write starts.
- R6: When the mask of a pending vector is cleared (its own mask bit or `func_mask_i`), the vector is sent using the table contents at that time, and its pending bit is cleared.
- R7: Address and data are captured when a write starts. Software writes to that vector's entry afterwards do not alter the write in flight, and AW/W hold their values until accepted.
- R8: When several vectors are deliverable at once, the lowest index is sent first.
- R9: At most one write is outstanding. No new `m_awvalid_o` rises until the previous write's response has been accepted with `m_bvalid_i` and `m_bready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| func_mask_i | input | 1 | Function-wide mask; blocks all delivery while high |
| irq_valid_i | input | 1 | Interrupt request strobe |
| irq_vec_i | input | IDX_W | Requested vector index |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | RA_W | Byte address (word aligned) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| m_awvalid_o | output | 1 | AXI write address valid |
| m_awready_i | input | 1 | AXI write address ready |
| m_awaddr_o | output | 64 | AXI write address |
| m_wvalid_o | output | 1 | AXI write data valid |
| m_wready_i | input | 1 | AXI write data ready |
| m_wdata_o | output | 32 | AXI write data |
| m_wstrb_o | output | 4 | AXI write strobes |
| m_wlast_o | output | 1 | AXI last beat |
| m_bvalid_i | input | 1 | AXI write response valid |
| m_bready_o | output | 1 | AXI write response ready |

## Verification
The bench builds the engine with NUM_VEC = 8. At that size the pending array is a single word at byte offset 128, so one read shows the whole array. Every vector fits in a short directed sequence, which lets the bench check the exact pending pattern after masked requests and observe the lowest-first order between vectors 1 and 6. Because the bench acts as the AXI slave and controls the ready and response timing, it can hold a write in flight while software rewrites the entry, and it can delay the response while a second vector waits.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_CTRL    = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_ADDR = 2'd1,
    WR_RESP = 2'd2
  } wr_st_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_we_i,
  input  logic [IDX_W-1:0]   sw_idx_i,
  input  fld_e               sw_fld_i,
  input  logic [31:0]        sw_wdata_i,
  output logic [31:0]        sw_rdata_o,
  input  logic [IDX_W-1:0]   eng_idx_i,
  output msg_t               eng_msg_o,
  output logic [NUM_VEC-1:0] mask_o
);
  logic [31:0]        lo_mem  [NUM_VEC];
  logic [31:0]        hi_mem  [NUM_VEC];
  logic [31:0]        dat_mem [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  always_ff @(posedge clk_i) begin
    if (sw_we_i) begin
      case (sw_fld_i)
        FLD_ADDR_LO: lo_mem[sw_idx_i]  <= sw_wdata_i;
        FLD_ADDR_HI: hi_mem[sw_idx_i]  <= sw_wdata_i;
        FLD_DATA:    dat_mem[sw_idx_i] <= sw_wdata_i;
        default: ;
      endcase
    end
  end

  // vectors come out of reset masked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else if (sw_we_i && sw_fld_i == FLD_CTRL) mask_q[sw_idx_i] <= sw_wdata_i[0];
  end

  always_comb begin
    case (sw_fld_i)
      FLD_ADDR_LO: sw_rdata_o = lo_mem[sw_idx_i];
      FLD_ADDR_HI: sw_rdata_o = hi_mem[sw_idx_i];
      FLD_DATA:    sw_rdata_o = dat_mem[sw_idx_i];
      default:     sw_rdata_o = {31'd0, mask_q[sw_idx_i]};
    endcase
  end

  assign eng_msg_o.addr = {hi_mem[eng_idx_i], lo_mem[eng_idx_i]};
  assign eng_msg_o.data = dat_mem[eng_idx_i];
  assign mask_o         = mask_q;

  p_mask_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && sw_fld_i == FLD_CTRL) |=> mask_o[$past(sw_idx_i)] == $past(sw_wdata_i[0]));
endmodule

// File: rtl/msix_pba.sv
module msix_pba #(
  parameter int NUM_VEC = 64,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  input  logic [NUM_VEC-1:0] mask_i,
  input  logic               func_mask_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic               sel_valid_o,
  output logic [IDX_W-1:0]   sel_idx_o
);
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] elig;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    // a new request wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else if (set_i && set_idx_i == IDX_W'(g)) pend_q[g] <= 1'b1;
      else if (clr_i && clr_idx_i == IDX_W'(g)) pend_q[g] <= 1'b0;
    end
  end

  assign elig = pend_q & ~mask_i & {NUM_VEC{~func_mask_i}};

  always_comb begin
    sel_idx_o = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i]) sel_idx_o = IDX_W'(i);
    end
  end

  assign sel_valid_o = |elig;
  assign pend_o      = pend_q;

  p_set_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q[$past(set_idx_i)]);
  p_fmask_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_mask_i |-> !sel_valid_o);
  p_sel_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (pend_q[sel_idx_o] && !mask_i[sel_idx_o]));
endmodule

// File: rtl/msix_axi_wr.sv
module msix_axi_wr
  import msix_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_valid_i,
  input  msg_t        msg_i,
  output logic        take_o,
  output logic        aw_valid_o,
  input  logic        aw_ready_i,
  output logic [63:0] aw_addr_o,
  output logic        w_valid_o,
  input  logic        w_ready_i,
  output logic [31:0] w_data_o,
  input  logic        b_valid_i,
  output logic        b_ready_o
);
  wr_st_e st_q;
  logic   aw_pend_q, w_pend_q;
  msg_t   msg_q;
  logic   aw_done, w_done;

  assign take_o  = (st_q == WR_IDLE) && sel_valid_i;
  assign aw_done = !aw_pend_q || aw_ready_i;
  assign w_done  = !w_pend_q || w_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= WR_IDLE;
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      msg_q     <= '0;
    end else begin
      case (st_q)
        WR_IDLE: if (sel_valid_i) begin
          msg_q     <= msg_i;  // snapshot before the bus sees it
          aw_pend_q <= 1'b1;
          w_pend_q  <= 1'b1;
          st_q      <= WR_ADDR;
        end
        WR_ADDR: begin
          if (aw_pend_q && aw_ready_i) aw_pend_q <= 1'b0;
          if (w_pend_q && w_ready_i)   w_pend_q  <= 1'b0;
          if (aw_done && w_done)       st_q      <= WR_RESP;
        end
        WR_RESP: if (b_valid_i) st_q <= WR_IDLE;
        default: st_q <= WR_IDLE;
      endcase
    end
  end

  assign aw_valid_o = aw_pend_q;
  assign w_valid_o  = w_pend_q;
  assign aw_addr_o  = msg_q.addr;
  assign w_data_o   = msg_q.data;
  assign b_ready_o  = (st_q == WR_RESP);

  p_aw_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_valid_o && !aw_ready_i) |=> (aw_valid_o && $stable(aw_addr_o)));
  p_w_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_o && !w_ready_i) |=> (w_valid_o && $stable(w_data_o)));
  p_one_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_ready_o |-> (!aw_valid_o && !w_valid_o));
  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_ready_o && !b_valid_i) |=> !aw_valid_o);
endmodule

// File: rtl/msix_engine.sv
module msix_engine
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int IDX_W   = $clog2(NUM_VEC),
  parameter int RA_W    = $clog2(NUM_VEC * 16 + ((NUM_VEC + 31) / 32) * 4)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             func_mask_i,
  input  logic             irq_valid_i,
  input  logic [IDX_W-1:0] irq_vec_i,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic             reg_rvalid_o,
  output logic [31:0]      reg_rdata_o,
  output logic             m_awvalid_o,
  input  logic             m_awready_i,
  output logic [63:0]      m_awaddr_o,
  output logic             m_wvalid_o,
  input  logic             m_wready_i,
  output logic [31:0]      m_wdata_o,
  output logic [3:0]       m_wstrb_o,
  output logic             m_wlast_o,
  input  logic             m_bvalid_i,
  output logic             m_bready_o
);
  localparam int PBA_WORDS = (NUM_VEC + 31) / 32;
  localparam logic [RA_W-1:0]  TBL_B = RA_W'(NUM_VEC * 16);
  localparam logic [RA_W-3:0]  PBA_N = (RA_W - 2)'(PBA_WORDS);
  localparam logic [IDX_W:0]   NV    = (IDX_W + 1)'(NUM_VEC);

  if (NUM_VEC < 2 || NUM_VEC > 2048) begin : g_bad_size
    $error("NUM_VEC must lie in 2..2048");
  end

  logic                     in_tbl, in_pba, irq_ok;
  logic [RA_W-1:0]          pba_off;
  logic [RA_W-3:0]          pba_word;
  logic [31:0]              tbl_rdata, pba_rdata;
  logic [NUM_VEC-1:0]       mask, pend;
  logic [PBA_WORDS*32-1:0]  pend_pad;
  logic                     sel_valid, take;
  logic [IDX_W-1:0]         sel_idx;
  msg_t                     sel_msg;

  assign in_tbl   = reg_addr_i < TBL_B;
  assign pba_off  = reg_addr_i - TBL_B;
  assign pba_word = pba_off[RA_W-1:2];
  assign in_pba   = !in_tbl && (pba_word < PBA_N);
  assign irq_ok   = irq_valid_i && ({1'b0, irq_vec_i} < NV);

  msix_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (reg_req_i && reg_we_i && in_tbl),
    .sw_idx_i   (reg_addr_i[4 +: IDX_W]),
    .sw_fld_i   (fld_e'(reg_addr_i[3:2])),
    .sw_wdata_i (reg_wdata_i),
    .sw_rdata_o (tbl_rdata),
    .eng_idx_i  (sel_idx),
    .eng_msg_o  (sel_msg),
    .mask_o     (mask)
  );

  msix_pba #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pba (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (irq_ok),
    .set_idx_i   (irq_vec_i),
    .clr_i       (take),
    .clr_idx_i   (sel_idx),
    .mask_i      (mask),
    .func_mask_i (func_mask_i),
    .pend_o      (pend),
    .sel_valid_o (sel_valid),
    .sel_idx_o   (sel_idx)
  );

  msix_axi_wr u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_valid_i (sel_valid),
    .msg_i       (sel_msg),
    .take_o      (take),
    .aw_valid_o  (m_awvalid_o),
    .aw_ready_i  (m_awready_i),
    .aw_addr_o   (m_awaddr_o),
    .w_valid_o   (m_wvalid_o),
    .w_ready_i   (m_wready_i),
    .w_data_o    (m_wdata_o),
    .b_valid_i   (m_bvalid_i),
    .b_ready_o   (m_bready_o)
  );

  assign m_wstrb_o = 4'hF;
  assign m_wlast_o = 1'b1;

  always_comb begin
    pend_pad              = '0;
    pend_pad[NUM_VEC-1:0] = pend;
    pba_rdata             = '0;
    for (int w = 0; w < PBA_WORDS; w++) begin
      if (pba_word == (RA_W - 2)'(w)) pba_rdata = pend_pad[w*32 +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvalid_o <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      reg_rvalid_o <= reg_req_i && !reg_we_i;
      if (reg_req_i && !reg_we_i)
        reg_rdata_o <= in_tbl ? tbl_rdata : (in_pba ? pba_rdata : 32'd0);
    end
  end

  p_pba_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && in_pba && !irq_valid_i && !take) |=> $stable(pend));
  p_rd_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i) |=> reg_rvalid_o);
endmodule

// File: tb/msix_engine_bench.sv
module msix_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV   = 8;
  localparam int RA_W = 8;
  localparam logic [RA_W-1:0] PBA_A = 8'd128;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             func_mask_i = 1'b0;
  logic             irq_valid_i = 1'b0;
  logic [2:0]       irq_vec_i = '0;
  logic             reg_req_i = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [RA_W-1:0]  reg_addr_i = '0;
  logic [31:0]      reg_wdata_i = '0;
  logic             reg_rvalid_o;
  logic [31:0]      reg_rdata_o;
  logic             m_awvalid_o, m_wvalid_o, m_wlast_o, m_bready_o;
  logic             m_awready_i = 1'b0, m_wready_i = 1'b0, m_bvalid_i = 1'b0;
  logic [63:0]      m_awaddr_o;
  logic [31:0]      m_wdata_o;
  logic [3:0]       m_wstrb_o;

  int n_chk = 0, n_fail = 0;
  bit timed_out = 0;
  logic [31:0] sh_lo [NV], sh_hi [NV], sh_dat [NV];

  always #(CLK_PERIOD / 2) clk = ~clk;

  msix_engine #(.NUM_VEC(NV)) u_msix_engine (
    .clk_i(clk), .rst_ni(rst_ni), .func_mask_i(func_mask_i),
    .irq_valid_i(irq_valid_i), .irq_vec_i(irq_vec_i),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rvalid_o(reg_rvalid_o), .reg_rdata_o(reg_rdata_o),
    .m_awvalid_o(m_awvalid_o), .m_awready_i(m_awready_i), .m_awaddr_o(m_awaddr_o),
    .m_wvalid_o(m_wvalid_o), .m_wready_i(m_wready_i), .m_wdata_o(m_wdata_o),
    .m_wstrb_o(m_wstrb_o), .m_wlast_o(m_wlast_o),
    .m_bvalid_i(m_bvalid_i), .m_bready_o(m_bready_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [RA_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic reg_rd(input logic [RA_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = a;
    @(negedge clk);
    reg_req_i = 0;
    chk(reg_rvalid_o, "R2", "rvalid", 64'(reg_rvalid_o), 64'd1);
    d = reg_rdata_o;
  endtask

  task automatic check_rd(input logic [RA_W-1:0] a, input logic [31:0] exp,
                          input string req, input string what);
    logic [31:0] d;
    reg_rd(a, d);
    chk(d == exp, req, what, 64'(d), 64'(exp));
  endtask

  task automatic irq(input int v);
    @(negedge clk);
    irq_valid_i = 1; irq_vec_i = 3'(v);
    @(negedge clk);
    irq_valid_i = 0;
  endtask

  task automatic no_write(input int cycles, input string req);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (m_awvalid_o || m_wvalid_o) seen = 1;
    end
    chk(!seen, req, "unexpected write", 64'(seen), 64'd0);
  endtask

  // acts as AXI slave; response held back 3 cycles to probe single-outstanding rule
  task automatic expect_write(input logic [63:0] ea, input logic [31:0] ed, input string req);
    int n = 0;
    while (!m_awvalid_o && n < 40) begin @(negedge clk); n++; end
    chk(m_awvalid_o && m_wvalid_o, req, "aw/w valid", 64'({m_awvalid_o, m_wvalid_o}), 64'd3);
    chk(m_awaddr_o == ea, req, "awaddr", m_awaddr_o, ea);
    chk(m_wdata_o == ed, req, "wdata", 64'(m_wdata_o), 64'(ed));
    chk(m_wstrb_o == 4'hF && m_wlast_o, "R5", "wstrb/wlast", 64'({m_wstrb_o, m_wlast_o}), 64'h1F);
    m_awready_i = 1; m_wready_i = 1;
    @(negedge clk);
    m_awready_i = 0; m_wready_i = 0;
    no_write(3, "R9");
    chk(m_bready_o, "R9", "bready", 64'(m_bready_o), 64'd1);
    m_bvalid_i = 1;
    @(negedge clk);
    m_bvalid_i = 0;
  endtask

  function automatic logic [63:0] ea_of(input int v);
    return {sh_hi[v], sh_lo[v]};
  endfunction

  task automatic t_reset;
    chk(!m_awvalid_o && !m_wvalid_o, "R1", "valid after reset",
        64'({m_awvalid_o, m_wvalid_o}), 64'd0);
    check_rd(8'd12, 32'd1, "R1", "mask v0");
    check_rd(8'd124, 32'd1, "R1", "mask v7");
    check_rd(PBA_A, 32'd0, "R1", "pba");
  endtask

  task automatic t_program;
    for (int v = 0; v < NV; v++) begin
      sh_lo[v] = 32'hFEE0_0000 | 32'(v << 2);
      sh_hi[v] = 32'h0000_1000 + 32'(v);
      sh_dat[v] = 32'hA500_0000 + 32'(v);
      reg_wr(8'(v * 16), sh_lo[v]);
      reg_wr(8'(v * 16 + 4), sh_hi[v]);
      reg_wr(8'(v * 16 + 8), sh_dat[v]);
    end
    check_rd(8'd64, sh_lo[4], "R2", "lo v4");
    check_rd(8'd68, sh_hi[4], "R2", "hi v4");
    check_rd(8'd72, sh_dat[4], "R2", "data v4");
    reg_wr(8'd76, 32'hFFFF_FFFF);
    check_rd(8'd76, 32'd1, "R2", "ctrl upper bits");
  endtask

  task automatic t_masked;
    irq(3);
    no_write(6, "R4");
    check_rd(PBA_A, 32'h08, "R4", "pba masked v3");
  endtask

  task automatic t_unmask;
    reg_wr(8'd60, 32'd0);
    expect_write(ea_of(3), sh_dat[3], "R6");
    check_rd(PBA_A, 32'h00, "R6", "pba after unmask");
  endtask

  task automatic t_direct;
    reg_wr(8'd92, 32'd0);
    irq(5);
    expect_write(ea_of(5), sh_dat[5], "R5");
    check_rd(PBA_A, 32'h00, "R5", "pba after send");
  endtask

  task automatic t_fmask_order;
    func_mask_i = 1;
    reg_wr(8'd28, 32'd0);
    reg_wr(8'd108, 32'd0);
    irq(6);
    irq(1);
    no_write(6, "R4");
    check_rd(PBA_A, 32'h42, "R4", "pba under func mask");
    @(negedge clk);
    func_mask_i = 0;
    expect_write(ea_of(1), sh_dat[1], "R8");
    expect_write(ea_of(6), sh_dat[6], "R8");
    check_rd(PBA_A, 32'h00, "R6", "pba after func unmask");
  endtask

  task automatic t_latch;
    logic [63:0] a0;
    int n = 0;
    reg_wr(8'd44, 32'd0);
    irq(2);
    while (!m_awvalid_o && n < 40) begin @(negedge clk); n++; end
    a0 = m_awaddr_o;
    reg_wr(8'd40, 32'hDEAD_BEEF);
    reg_wr(8'd32, 32'h0000_1234);
    @(negedge clk);
    chk(m_awaddr_o == a0 && m_awvalid_o, "R7", "aw stable", m_awaddr_o, a0);
    expect_write(ea_of(2), sh_dat[2], "R7");
    sh_dat[2] = 32'hDEAD_BEEF;
    sh_lo[2]  = 32'h0000_1234;
    irq(2);
    expect_write(ea_of(2), sh_dat[2], "R6");
  endtask

  task automatic t_pba_ro;
    irq(0);
    no_write(3, "R4");
    check_rd(PBA_A, 32'h01, "R3", "pba v0");
    reg_wr(PBA_A, 32'hFFFF_FFFF);
    check_rd(PBA_A, 32'h01, "R3", "pba after write ones");
    reg_wr(PBA_A, 32'h0);
    check_rd(PBA_A, 32'h01, "R3", "pba after write zero");
    reg_wr(8'd12, 32'd0);
    expect_write(ea_of(0), sh_dat[0], "R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    fork
      begin
        t_reset;
        t_program;
        t_masked;
        t_unmask;
        t_direct;
        t_fmask_order;
        t_latch;
        t_pba_ro;
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(0, "ALL", "watchdog", 64'd1, 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule